// File: doc/BRIEF.md
# Direct-Mapped Trace Reduction Filter

This block shrinks a stream of memory references before it reaches a slower cache model. Every reference is looked up in a small direct-mapped filter cache with one frame per set. A reference that hits is deleted from the stream and counted. A reference that misses is forwarded, and its block replaces whatever the frame held. When write-back mode is on, a write that hits a clean resident block is also forwarded, and the block is marked dirty. The reduced stream then gives the same miss count and the same write-back count as the full stream in any larger cache whose set mapping refines the filter's mapping.

References arrive on a valid/ready stream that carries a byte address and a write flag. Retained references leave on a second valid/ready stream through a one-entry output register. The input's ready follows the output's ready directly, so a stalled consumer stalls the producer and nothing is lost or reordered. Three counters report how many references were taken in, how many were deleted and how many were forwarded.

Top module: `trace_filter`

## Requirements
- R1: After reset, out_valid is 0, all three counters are 0, and every frame is invalid, so the first reference to any address is a miss.
- R2: The set index is the block address modulo NUM_SETS, which is address bits [OFF_W+SET_W-1:OFF_W] with OFF_W = log2(BLOCK_BYTES). The tag is the bits above these. With the defaults (16-byte blocks, 16 sets), the set is bits [7:4] and the tag is bits [31:8].
- R3: A reference that misses is forwarded. out_valid is 1 after the clock edge that accepts it, and out_addr and out_write equal the accepted address and write flag.
- R4: A read that hits, meaning the frame is valid with a matching tag, is not forwarded and increments the dropped counter.
- R5: With wb_mode = 1, a write that hits a clean block is forwarded with out_write = 1 and marks the block dirty. A later write hit to the same block is dropped.
- R6: With wb_mode = 0, every write that hits is dropped.
- R7: A miss loads the frame's dirty bit from its write flag, so with wb_mode = 1 a write that follows a write miss to the same block is dropped.
- R8: A miss to a set replaces that set's frame only. The evicted block misses again, and frames in other sets are left untouched.
- R9: in_ready equals out_ready. While out_ready is 0, no reference is accepted, the counters hold, and a pending output keeps out_valid, out_addr and out_write stable.
- R10: Each accepted reference increments cnt_total by one and increments exactly one of cnt_dropped and cnt_kept, so cnt_total = cnt_dropped + cnt_kept at all times.
- R11: Addresses that differ only in the block offset bits map to the same block, so a reference to another byte of a resident block hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wb_mode | input | 1 | 1 forwards the first write hit to each clean block |
| in_valid | input | 1 | Input reference valid |
| in_ready | output | 1 | Input reference accepted when high with in_valid |
| in_addr | input | ADDR_W | Byte address of the reference |
| in_write | input | 1 | 1 for a write, 0 for a read |
| out_valid | output | 1 | Retained reference available |
| out_ready | input | 1 | Consumer takes the retained reference |
| out_addr | output | ADDR_W | Address of the retained reference |
| out_write | output | 1 | Write flag of the retained reference |
| cnt_total | output | CNT_W | References accepted |
| cnt_dropped | output | CNT_W | References deleted |
| cnt_kept | output | CNT_W | References forwarded |

## Verification
Two things can happen in the same cycle: the consumer takes the pending output entry, and the next reference is classified and written into the tag store. The bench makes this happen by sending a reference back to back after a retained one while out_ready is high, and by releasing a stall while a new reference is waiting. It then checks that the new entry replaces the old one without loss and that the counters advance exactly once. A second overlap is a lookup that follows an update of the same set. Consecutive write-miss, write-hit and read-hit sequences to one block test this, and each outcome is judged from the forwarded stream and the counters.

// File: rtl/tf_pkg.sv
package tf_pkg;

    // How a single reference is treated by the filter
    typedef enum logic [1:0] {
        FATE_DROP_HIT    = 2'd0,
        FATE_KEEP_MISS   = 2'd1,
        FATE_KEEP_FIRSTW = 2'd2,
        FATE_DROP_DIRTYW = 2'd3
    } fate_t;

    function automatic logic fate_keeps(input fate_t f);
        return (f == FATE_KEEP_MISS) || (f == FATE_KEEP_FIRSTW);
    endfunction

    // Dirty state a frame takes after a reference is applied
    function automatic logic next_dirty(input logic hit, input logic cur_dirty,
                                        input logic is_write);
        return hit ? (cur_dirty | is_write) : is_write;
    endfunction

endpackage

// File: rtl/tf_tag_store.sv
module tf_tag_store #(
    parameter int NUM_SETS = 16,
    parameter int SET_W    = 4,
    parameter int TAG_W    = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SET_W-1:0] lk_set,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    output logic             lk_dirty,
    input  logic             upd_en,
    input  logic             upd_write
);
    import tf_pkg::*;

    logic [NUM_SETS-1:0] frm_valid;
    logic [NUM_SETS-1:0] frm_dirty;
    logic [TAG_W-1:0]    frm_tag [NUM_SETS];

    always_comb begin
        lk_hit   = frm_valid[lk_set] && (frm_tag[lk_set] == lk_tag);
        lk_dirty = frm_dirty[lk_set];
    end

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_frame
        always_ff @(posedge clk) begin
            if (rst) begin
                frm_valid[s] <= 1'b0;
                frm_dirty[s] <= 1'b0;
                frm_tag[s]   <= '0;
            end else if (upd_en && (lk_set == SET_W'(s))) begin
                frm_valid[s] <= 1'b1;
                frm_tag[s]   <= lk_tag;
                frm_dirty[s] <= next_dirty(lk_hit, lk_dirty, upd_write);
            end
        end
    end

    // R8: an update leaves the block resident in its set on the next cycle
    p_resident_r8: assert property (@(posedge clk) disable iff (rst)
        upd_en |=> frm_valid[$past(lk_set)] && (frm_tag[$past(lk_set)] == $past(lk_tag)));

endmodule

// File: rtl/tf_classify.sv
module tf_classify (
    input  logic          hit,
    input  logic          dirty,
    input  logic          is_write,
    input  logic          wb_mode,
    output tf_pkg::fate_t fate
);
    import tf_pkg::*;

    always_comb begin
        if (!hit)
            fate = FATE_KEEP_MISS;
        else if (!is_write)
            fate = FATE_DROP_HIT;
        else if (wb_mode && !dirty)
            fate = FATE_KEEP_FIRSTW;
        else
            fate = FATE_DROP_DIRTYW;
    end

endmodule

// File: rtl/tf_counters.sv
module tf_counters #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic             kept,
    output logic [CNT_W-1:0] total,
    output logic [CNT_W-1:0] dropped,
    output logic [CNT_W-1:0] forwarded
);
    always_ff @(posedge clk) begin
        if (rst) begin
            total     <= '0;
            dropped   <= '0;
            forwarded <= '0;
        end else if (take) begin
            total <= total + CNT_W'(1);
            if (kept) forwarded <= forwarded + CNT_W'(1);
            else      dropped   <= dropped + CNT_W'(1);
        end
    end

    p_sum_r10: assert property (@(posedge clk) disable iff (rst)
        total == dropped + forwarded);

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !take |=> $stable(total));

endmodule

// File: rtl/trace_filter.sv
module trace_filter #(
    parameter int ADDR_W      = 32,
    parameter int BLOCK_BYTES = 16,
    parameter int NUM_SETS    = 16,
    parameter int CNT_W       = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wb_mode,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic              in_write,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_write,
    output logic [CNT_W-1:0]  cnt_total,
    output logic [CNT_W-1:0]  cnt_dropped,
    output logic [CNT_W-1:0]  cnt_kept
);
    import tf_pkg::*;

    localparam int OFF_W = $clog2(BLOCK_BYTES);
    localparam int SET_W = $clog2(NUM_SETS);
    localparam int TAG_W = ADDR_W - OFF_W - SET_W;

    logic             accept;
    logic [SET_W-1:0] set_idx;
    logic [TAG_W-1:0] tag_val;
    logic             hit, dirty, keep;
    fate_t            fate;

    assign in_ready = out_ready;
    assign accept   = in_valid && in_ready;
    assign set_idx  = in_addr[OFF_W +: SET_W];
    assign tag_val  = in_addr[ADDR_W-1 -: TAG_W];

    tf_tag_store #(.NUM_SETS(NUM_SETS), .SET_W(SET_W), .TAG_W(TAG_W)) u_store (
        .clk(clk), .rst(rst),
        .lk_set(set_idx), .lk_tag(tag_val),
        .lk_hit(hit), .lk_dirty(dirty),
        .upd_en(accept), .upd_write(in_write)
    );

    tf_classify u_cls (
        .hit(hit), .dirty(dirty), .is_write(in_write),
        .wb_mode(wb_mode), .fate(fate)
    );

    assign keep = fate_keeps(fate);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_addr  <= '0;
            out_write <= 1'b0;
        end else if (accept) begin
            out_valid <= keep;
            if (keep) begin
                out_addr  <= in_addr;
                out_write <= in_write;
            end
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    tf_counters #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .take(accept), .kept(keep),
        .total(cnt_total), .dropped(cnt_dropped), .forwarded(cnt_kept)
    );

    p_miss_fwd_r3: assert property (@(posedge clk) disable iff (rst)
        accept && !hit |=> out_valid && (out_addr == $past(in_addr))
                           && (out_write == $past(in_write)));

    p_read_hit_drop_r4: assert property (@(posedge clk) disable iff (rst)
        accept && hit && !in_write |=> !out_valid);

    p_first_write_r5: assert property (@(posedge clk) disable iff (rst)
        accept && hit && in_write && wb_mode && !dirty |=> out_valid && out_write);

    p_stall_hold_r9: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_write));

endmodule

// File: tb/trace_filter_test.sv
module trace_filter_test;
    localparam int AW = 32;
    localparam int CW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wb_mode = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [AW-1:0] in_addr = '0;
    logic          in_write = 1'b0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [AW-1:0] out_addr;
    logic          out_write;
    logic [CW-1:0] cnt_total, cnt_dropped, cnt_kept;

    int checks = 0;
    int failures = 0;
    int e_total = 0, e_drop = 0, e_kept = 0;

    always #5 clk = ~clk;

    trace_filter uut (
        .clk(clk), .rst(rst), .wb_mode(wb_mode),
        .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr), .in_write(in_write),
        .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr), .out_write(out_write),
        .cnt_total(cnt_total), .cnt_dropped(cnt_dropped), .cnt_kept(cnt_kept)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_counts(input string req);
        chk({req, " total"}, cnt_total, e_total);
        chk({req, " dropped"}, cnt_dropped, e_drop);
        chk({req, " kept"}, cnt_kept, e_kept);
    endtask

    // One reference with out_ready high; checks the forwarded stream
    task automatic send(input logic [AW-1:0] a, input logic w, input logic exp_keep,
                        input string req);
        @(negedge clk);
        in_valid = 1'b1; in_addr = a; in_write = w;
        @(posedge clk); #1;
        e_total++;
        if (exp_keep) e_kept++; else e_drop++;
        chk({req, " out_valid"}, out_valid, exp_keep);
        if (exp_keep) begin
            chk({req, " out_addr"}, out_addr, a);
            chk({req, " out_write"}, out_write, w);
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 out_valid", out_valid, 0);
        chk_counts("R1");
        chk("R9 in_ready follows out_ready", in_ready, 1);
    endtask

    task automatic t_basic;
        send(32'h0000_1230, 1'b0, 1'b1, "R1 R3 first read misses");
        send(32'h0000_1234, 1'b0, 1'b0, "R11 R4 same block hits");
        send(32'h0000_123C, 1'b0, 1'b0, "R11 last byte hits");
        send(32'h0000_1330, 1'b0, 1'b1, "R2 tag bit 8 differs misses");
        send(32'h0000_1240, 1'b1, 1'b1, "R2 R3 other set write miss");
        chk_counts("R10 after basic");
    endtask

    task automatic t_conflict;
        send(32'h0000_4530, 1'b0, 1'b1, "R8 conflicting block misses");
        send(32'h0000_1230, 1'b0, 1'b1, "R8 evicted block misses");
        send(32'h0000_1248, 1'b0, 1'b0, "R8 other set untouched");
    endtask

    task automatic t_no_wb;
        wb_mode = 1'b0;
        send(32'h0000_1230, 1'b1, 1'b0, "R6 write hit dropped");
        send(32'h0000_1230, 1'b1, 1'b0, "R6 second write hit dropped");
    endtask

    task automatic t_wb;
        wb_mode = 1'b1;
        send(32'h2000_0050, 1'b0, 1'b1, "R5 read miss");
        send(32'h2000_0054, 1'b1, 1'b1, "R5 first write to clean kept");
        send(32'h2000_0058, 1'b1, 1'b0, "R5 write to dirty dropped");
        send(32'h2000_0050, 1'b0, 1'b0, "R5 read hit dropped");
        send(32'h3000_0060, 1'b1, 1'b1, "R7 write miss kept");
        send(32'h3000_0064, 1'b1, 1'b0, "R7 write after write miss dropped");
        chk_counts("R10 after wb");
    endtask

    task automatic t_backpressure;
        @(negedge clk);
        out_ready = 1'b0;
        in_valid = 1'b1; in_addr = 32'h4000_0070; in_write = 1'b0;
        #1;
        chk("R9 in_ready low", in_ready, 0);
        repeat (2) @(posedge clk);
        #1;
        chk("R9 no output while stalled", out_valid, 0);
        chk_counts("R9 stalled");
        @(negedge clk);
        out_ready = 1'b1;
        @(posedge clk); #1;
        e_total++; e_kept++;
        chk("R9 accepted after release", out_valid, 1);
        chk("R9 addr after release", out_addr, 32'h4000_0070);
        @(negedge clk);
        in_valid = 1'b0;
        out_ready = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R9 pending held valid", out_valid, 1);
        chk("R9 pending addr stable", out_addr, 32'h4000_0070);
        chk("R9 pending write stable", out_write, 0);
        @(negedge clk);
        out_ready = 1'b1;
        @(posedge clk); #1;
        chk("R9 drained", out_valid, 0);
        chk_counts("R10 after backpressure");
    endtask

    // Back-to-back retained references: consumer drains while next is classified
    task automatic t_back_to_back;
        @(negedge clk);
        in_valid = 1'b1; in_addr = 32'h5000_0080; in_write = 1'b0;
        @(posedge clk); #1;
        e_total++; e_kept++;
        chk("R3 b2b first", out_addr, 32'h5000_0080);
        @(negedge clk);
        in_addr = 32'h6000_0090; in_write = 1'b1;
        @(posedge clk); #1;
        e_total++; e_kept++;
        chk("R3 b2b second valid", out_valid, 1);
        chk("R3 b2b second addr", out_addr, 32'h6000_0090);
        @(negedge clk);
        in_addr = 32'h6000_0094; in_write = 1'b0;
        @(posedge clk); #1;
        e_total++; e_drop++;
        chk("R4 b2b hit after update", out_valid, 0);
        @(negedge clk);
        in_valid = 1'b0;
        chk_counts("R10 after b2b");
    endtask

    initial begin
        fork
            begin
                repeat (3) @(posedge clk);
                @(negedge clk);
                rst = 1'b0;
                #1;
                t_reset();
                t_basic();
                t_conflict();
                t_no_wb();
                t_wb();
                t_backpressure();
                t_back_to_back();
            end
            begin
                repeat (5000) @(posedge clk);
                failures++;
                checks++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule